// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block decides whether a captured buffer of 64-bit words holds enough values from a known shift-register sequence. After a start pulse it loads one of two seed words, picked by a version-select input, and reads the buffer one word per cycle through a synchronous read port. Every word equal to the current expected value adds one to a running match total. After each pass over the buffer, the total is compared with a goal. If the goal is not met, the expected value advances by one Galois step under a programmed polynomial mask, and the block scans the buffer again.

The run stops with pass when the total reaches the goal. It stops with fail when the programmed number of scans has been used up. Buffer word 0 is never read or counted. On fail, two diagnostic outputs hold the final expected value and the match total. The result stays on the outputs until the next start pulse. The polynomial, goal and scan limit must be held steady during a run. The block is intended for a power-on health check of a random source, where the capture logic fills the buffer before the check is started.

Top module: `lfsr_selftest_chk`

## Requirements
- R1: One advance step shifts the expected value left by one bit. When bit 63 was 1 before the shift, the result is also XORed with the polynomial mask.
- R2: Word index 0 of the buffer is never addressed, and a value stored there never counts as a match.
- R3: Each scan adds the number of words (indices 1 to DEPTH-1) equal to the expected value to a running total. The total is not cleared between scans and saturates at its maximum.
- R4: After each scan the total is compared with the goal first. If total >= goal, the run ends with pass and the expected value does not advance, so a goal of 0 passes after the first scan.
- R5: When the scan limit is used up without meeting the goal, the run ends with fail. A limit of 0 fails at once, with no reads.
- R6: With ver_sel_i = 0 the run starts from seed0_i. With ver_sel_i = 1 it starts from seed1_i.
- R7: During a scan, rd_en_o is high and rd_addr_o steps 1, 2, ..., DEPTH-1 on consecutive cycles, and rd_data_i is taken one cycle after its address. A run of k scans raises done_o exactly k*(DEPTH+1) cycles after the clock edge that samples start_i.
- R8: start_i is honoured in any state. It clears the total and the scan count and loads the seed. done_o, pass_o and fail_o hold their values until the next start.
- R9: While fail_o is high, diag_value_o holds the seed advanced limit times and diag_count_o holds the total. Both are 0 whenever fail_o is low.
- R10: After reset, done_o, pass_o, fail_o and rd_en_o are 0, and both diagnostic outputs are 0.
- R11: pass_o and fail_o are never both high. Exactly one of them is high whenever done_o is high, and neither is high when done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a check |
| ver_sel_i | input | 1 | Seed select (0: seed0_i, 1: seed1_i) |
| seed0_i | input | W | Seed for version 0 |
| seed1_i | input | W | Seed for version 1 |
| poly_i | input | W | Polynomial feedback mask |
| goal_i | input | CNT_W | Match total needed for pass |
| limit_i | input | LOOP_W | Maximum number of scans |
| rd_en_o | output | 1 | Buffer read request |
| rd_addr_o | output | $clog2(DEPTH) | Buffer word address |
| rd_data_i | input | W | Buffer word, valid one cycle after the request |
| done_o | output | 1 | Check finished |
| pass_o | output | 1 | Goal was met |
| fail_o | output | 1 | Scan limit used up |
| diag_value_o | output | W | Final expected value when failed |
| diag_count_o | output | CNT_W | Match total when failed |

## Verification
A wrong step in the polynomial advance shows up in diag_value_o at the end of a failing run. A lost or extra match count shows up in diag_count_o, or as a pass arriving one or more scans early or late. The bench measures this to the exact cycle, because each scan takes DEPTH+1 cycles. A read of word 0, or a skipped or repeated address, is visible on the read port in the cycle it happens. A total that is not cleared on restart shows up as an early pass in the run that follows.

// File: rtl/chk_pkg.sv
package chk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SCAN   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_DECIDE = 3'd3,
        ST_DONE   = 3'd4
    } chk_state_e;
endpackage

// File: rtl/chk_galois_step.sv
module chk_galois_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] poly_i,
    output logic [W-1:0] nxt_i
);
    logic [W-1:0] shifted;
    always_comb begin
        shifted = {cur_i[W-2:0], 1'b0};
        nxt_i   = cur_i[W-1] ? (shifted ^ poly_i) : shifted;
    end
endmodule

// File: rtl/chk_match_acc.sv
module chk_match_acc #(
    parameter int W     = 64,
    parameter int CNT_W = 16
) (
    input  logic [W-1:0]     word_i,
    input  logic [W-1:0]     expect_i,
    input  logic [CNT_W-1:0] total_i,
    output logic [CNT_W-1:0] total_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = '1;
    always_comb begin
        if (word_i == expect_i && total_i != MAX_CNT)
            total_o = total_i + 1'b1;
        else
            total_o = total_i;
    end
endmodule

// File: rtl/lfsr_selftest_chk.sv
module lfsr_selftest_chk #(
    parameter int W      = 64,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int LOOP_W = 16,
    localparam int AW    = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ver_sel_i,
    input  logic [W-1:0]      seed0_i,
    input  logic [W-1:0]      seed1_i,
    input  logic [W-1:0]      poly_i,
    input  logic [CNT_W-1:0]  goal_i,
    input  logic [LOOP_W-1:0] limit_i,
    output logic              rd_en_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [W-1:0]      rd_data_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [W-1:0]      diag_value_o,
    output logic [CNT_W-1:0]  diag_count_o
);
    import chk_pkg::*;

    localparam logic [AW-1:0] LAST_IDX  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] FIRST_IDX = AW'(1);

    typedef struct packed {
        chk_state_e        st;
        logic [AW-1:0]     idx;
        logic              vld;
        logic [W-1:0]      expv;
        logic [CNT_W-1:0]  total;
        logic [LOOP_W-1:0] iter;
        logic              pass;
        logic              fail;
    } chk_reg_t;

    chk_reg_t r_d, r_q;

    logic [W-1:0]      step_val;
    logic [CNT_W-1:0]  acc_val;
    logic [LOOP_W-1:0] iter_nx;

    chk_galois_step #(.W(W)) u_step (
        .cur_i (r_q.expv),
        .poly_i(poly_i),
        .nxt_i (step_val)
    );

    chk_match_acc #(.W(W), .CNT_W(CNT_W)) u_acc (
        .word_i  (rd_data_i),
        .expect_i(r_q.expv),
        .total_i (r_q.total),
        .total_o (acc_val)
    );

    always_comb begin
        r_d     = r_q;
        iter_nx = LOOP_W'(r_q.iter + 1'b1);
        r_d.vld = (r_q.st == ST_SCAN);
        if (r_q.vld)
            r_d.total = acc_val;

        case (r_q.st)
            ST_SCAN: begin
                if (r_q.idx == LAST_IDX)
                    r_d.st = ST_WAIT;
                else
                    r_d.idx = AW'(r_q.idx + 1'b1);
            end
            ST_WAIT: r_d.st = ST_DECIDE;
            ST_DECIDE: begin
                if (r_q.total >= goal_i) begin
                    r_d.pass = 1'b1;
                    r_d.st   = ST_DONE;
                end else begin
                    r_d.expv = step_val;
                    r_d.iter = iter_nx;
                    if (iter_nx == limit_i) begin
                        r_d.fail = 1'b1;
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.st  = ST_SCAN;
                        r_d.idx = FIRST_IDX;
                    end
                end
            end
            default: ;
        endcase

        if (start_i) begin
            r_d.st    = (limit_i == '0) ? ST_DONE : ST_SCAN;
            r_d.fail  = (limit_i == '0);
            r_d.pass  = 1'b0;
            r_d.total = '0;
            r_d.iter  = '0;
            r_d.idx   = FIRST_IDX;
            r_d.vld   = 1'b0;
            r_d.expv  = ver_sel_i ? seed1_i : seed0_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.idx   <= FIRST_IDX;
            r_q.vld   <= 1'b0;
            r_q.expv  <= '0;
            r_q.total <= '0;
            r_q.iter  <= '0;
            r_q.pass  <= 1'b0;
            r_q.fail  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_en_o      = (r_q.st == ST_SCAN);
        rd_addr_o    = r_q.idx;
        done_o       = (r_q.st == ST_DONE);
        pass_o       = r_q.pass;
        fail_o       = r_q.fail;
        diag_value_o = r_q.fail ? r_q.expv  : '0;
        diag_count_o = r_q.fail ? r_q.total : '0;
    end
endmodule

// File: rtl/lfsr_selftest_chk_sva.sv
module lfsr_selftest_chk_sva #(
    parameter int W      = 64,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int AW     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             rd_en_o,
    input logic [AW-1:0]    rd_addr_o,
    input logic             done_o,
    input logic             pass_o,
    input logic             fail_o,
    input logic [W-1:0]     diag_value_o,
    input logic [CNT_W-1:0] diag_count_o
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot({pass_o, fail_o}));

    assert_no_result_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!pass_o && !fail_o));

    assert_skip_word0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_addr_o != '0));

    assert_addr_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && rd_addr_o != LAST_IDX && !start_i)
            |=> (rd_en_o && rd_addr_o == AW'($past(rd_addr_o) + 1'b1)));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(diag_count_o)
                                  && $stable(diag_value_o)));

    assert_diag_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fail_o |-> (diag_count_o == '0 && diag_value_o == '0));

    assert_no_read_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_en_o);
endmodule

bind lfsr_selftest_chk lfsr_selftest_chk_sva #(
    .W(W), .DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .diag_value_o(diag_value_o),
    .diag_count_o(diag_count_o)
);

// File: tb/sim_lfsr_selftest_chk.sv
`timescale 1ns/1ps
module sim_lfsr_selftest_chk;
    localparam int W      = 64;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = 16;
    localparam int LOOP_W = 16;
    localparam int AW     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              ver_sel_i = 1'b0;
    logic [W-1:0]      seed0_i = '0, seed1_i = '0, poly_i = '0;
    logic [CNT_W-1:0]  goal_i = '0;
    logic [LOOP_W-1:0] limit_i = '0;
    logic              rd_en_o;
    logic [AW-1:0]     rd_addr_o;
    logic [W-1:0]      rd_data_i = '0;
    logic              done_o, pass_o, fail_o;
    logic [W-1:0]      diag_value_o;
    logic [CNT_W-1:0]  diag_count_o;

    logic [W-1:0] mem [DEPTH];

    int checks = 0, fails = 0, bad_addr = 0;
    bit finished = 1'b0;

    bit          e_pass;
    logic [W-1:0] e_val;
    int          e_cnt, e_scans;

    always #5 clk = ~clk;

    lfsr_selftest_chk #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LOOP_W(LOOP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ver_sel_i(ver_sel_i),
        .seed0_i(seed0_i), .seed1_i(seed1_i), .poly_i(poly_i), .goal_i(goal_i),
        .limit_i(limit_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
        .diag_value_o(diag_value_o), .diag_count_o(diag_count_o)
    );

    always_ff @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

    always @(negedge clk)
        if (rd_en_o && (rd_addr_o == '0 || int'(rd_addr_o) > DEPTH - 1)) bad_addr++;

    function automatic logic [W-1:0] adv(logic [W-1:0] v, logic [W-1:0] p);
        return v[W-1] ? ((v << 1) ^ p) : (v << 1);
    endfunction

    function automatic void model();
        logic [W-1:0] v = ver_sel_i ? seed1_i : seed0_i;
        int tot = 0;
        e_pass = 1'b0; e_scans = int'(limit_i);
        for (int it = 0; it < int'(limit_i); it++) begin
            for (int k = 1; k < DEPTH; k++) if (mem[k] == v && tot < 65535) tot++;
            if (tot >= int'(goal_i)) begin
                e_pass = 1'b1; e_scans = it + 1; break;
            end
            v = adv(v, poly_i);
        end
        e_val = e_pass ? '0 : v;
        e_cnt = e_pass ? 0 : tot;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fill_junk();
        for (int k = 0; k < DEPTH; k++) mem[k] = {$urandom(), $urandom()};
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_check(string req);
        int n = 0;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        chk(done_o, req, "done", W'(done_o), W'(1));
        chk(pass_o == e_pass && fail_o == !e_pass, req, "pass/fail (R4 R5 R11)",
            W'({pass_o, fail_o}), W'({e_pass, !e_pass}));
        chk(diag_value_o == e_val, req, "diag value (R1 R9)", diag_value_o, e_val);
        chk(int'(diag_count_o) == e_cnt, req, "diag count (R3 R9)", W'(diag_count_o), W'(e_cnt));
        chk(n == e_scans * (DEPTH + 1), req, "latency (R7)", W'(n), W'(e_scans * (DEPTH + 1)));
    endtask

    task automatic run(string req);
        model();
        pulse_start();
        wait_check(req);
    endtask

    initial begin
        #(64'd200000 * 10);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] s;
        void'($urandom(32'h1234_5eed));
        fill_junk();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!done_o && !pass_o && !fail_o && !rd_en_o, "R10", "ctrl after reset",
            W'({done_o, pass_o, fail_o, rd_en_o}), '0);
        chk(diag_value_o == '0 && diag_count_o == '0, "R10", "diag after reset",
            diag_value_o, '0);

        poly_i = {$urandom(), $urandom()} | 64'h1;
        seed0_i = {$urandom(), $urandom()};
        seed1_i = {$urandom(), $urandom()};

        // R2: match only at word 0 is ignored
        fill_junk(); ver_sel_i = 0; mem[0] = seed0_i; goal_i = 1; limit_i = 1;
        run("R2");

        // R4: several matches in one scan pass at once
        fill_junk(); mem[1] = seed0_i; mem[2] = seed0_i; mem[3] = seed0_i;
        goal_i = 3; limit_i = 4;
        run("R4");

        // R3: matches accumulate across steps
        fill_junk(); s = seed0_i;
        mem[2] = s; s = adv(s, poly_i); mem[5] = s; s = adv(s, poly_i); mem[6] = s;
        goal_i = 3; limit_i = 5;
        run("R3");
        goal_i = 4; limit_i = 3;
        run("R3");

        // R5: zero limit fails at once
        limit_i = 0; goal_i = 0;
        run("R5");

        // R4: zero goal passes after one scan
        limit_i = 2;
        run("R4");

        // R6: seed selection
        fill_junk(); mem[4] = seed0_i; goal_i = 1; limit_i = 1;
        ver_sel_i = 1; run("R6");
        ver_sel_i = 0; run("R6");

        // R1: feedback applied when bit 63 is set
        seed0_i = 64'h8000_0000_0000_0001; limit_i = 1; goal_i = 1; fill_junk();
        run("R1");
        chk(diag_value_o == (64'h2 ^ poly_i), "R1", "step with feedback",
            diag_value_o, 64'h2 ^ poly_i);

        // R8: result held until next start
        repeat (5) @(negedge clk);
        chk(done_o && fail_o, "R8", "result held", W'({done_o, fail_o}), W'(2'b11));

        // R8: restart in the middle of a scan
        fill_junk(); seed0_i = {$urandom(), $urandom()};
        mem[1] = seed0_i; mem[7] = seed0_i; goal_i = 4; limit_i = 6;
        pulse_start();
        repeat (12) @(negedge clk);
        goal_i = 2; limit_i = 3;
        run("R8");

        // random mix
        for (int t = 0; t < 40; t++) begin
            fill_junk();
            poly_i    = {$urandom(), $urandom()};
            seed0_i   = {$urandom(), $urandom()};
            seed1_i   = {$urandom(), $urandom()};
            ver_sel_i = $urandom_range(0, 1);
            limit_i   = LOOP_W'($urandom_range(0, 6));
            goal_i    = CNT_W'($urandom_range(0, 5));
            for (int k = 0; k < DEPTH; k++) begin
                if ($urandom_range(0, 1) == 1) begin
                    s = ver_sel_i ? seed1_i : seed0_i;
                    for (int j = $urandom_range(0, 6); j > 0; j--) s = adv(s, poly_i);
                    mem[k] = s;
                end
            end
            run("R3");
        end

        chk(bad_addr == 0, "R7", "illegal read address seen", W'(bad_addr), '0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule